// File: doc/BRIEF.md
# Rectangle Blit Setup Resolver

This block sits in front of a 2D drawing engine and converts one rectangle request, either a copy or a solid fill, into the five command words that start the engine. A copy request names a source corner, a destination corner, a width and a height. The block picks the scan order along each axis so that a copy whose source and destination overlap never reads a pixel it has already overwritten. When a scan runs backwards along an axis, it moves both start corners to the far edge on that axis.

For 24-bit pixels the engine moves bytes, so every horizontal quantity is tripled. A byte-rotation index, a remainder modulo 6, tells the engine where the first pixel lands within its 3-byte lane pattern. This remainder is found by a serial divider that takes several cycles. A fill always scans forward on both axes. It spreads its 8-bit colour across the three low bytes of the colour word.

Requests arrive on a valid/ready handshake. Each result is held on a second valid/ready handshake until the downstream side takes it. Only one request is in flight at a time.

Top module: `blit_setup_resolver`

## Requirements
- R1: A request with width 0 or height 0 is accepted and then discarded. It produces no command, and the block stays ready for the next request.
- R2: With the 24-bit flag set, source x, destination x and width are each multiplied by 3 (modulo 2^16) before direction and corner handling. The size word carries the tripled width.
- R3: For a copy with source y below destination y, both y starts become y + height - 1 and control bit 1 (top-to-bottom) is 0. Otherwise the y starts are unchanged and bit 1 is 1.
- R4: For a copy with the (scaled) source x below the (scaled) destination x, both x starts become x + width - 1 and control bit 0 (left-to-right) is 0. Otherwise the x starts are unchanged and bit 0 is 1.
- R5: With the 24-bit flag set, control bit 7 is 1 and control bits [10:8] hold the rotation. The rotation is (dx >> 2) mod 6 when bit 0 is 1, and ((dx + 2) >> 2) mod 6 when bit 0 is 0, where dx is the final destination x start. With the flag clear, bits [10:7] are 0. All control bits not named in R3 to R8 are 0.
- R6: The position words carry x in [31:16] and y in [15:0]. The size word carries width in [31:16] and height in [15:0].
- R7: A fill sets control bits 0, 1 and 5, uses the destination corner unchanged (x scaled per R2), outputs a source word of 0, and outputs a colour word whose bytes [7:0], [15:8] and [23:16] equal the request colour, with [31:24] zero.
- R8: A copy sets control bit 5 (last pixel) and outputs a colour word of 0.
- R9: While a command is valid and not taken, all five command words stay unchanged and req_ready is low. Commands leave in the order the requests were accepted.
- R10: After reset, cmd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_fill | input | 1 | 1 = fill, 0 = copy |
| req_px24 | input | 1 | 24-bit pixel mode |
| req_src_x | input | 16 | Source x |
| req_src_y | input | 16 | Source y |
| req_dst_x | input | 16 | Destination x |
| req_dst_y | input | 16 | Destination y |
| req_width | input | 16 | Width in pixels |
| req_height | input | 16 | Height in lines |
| req_colour | input | 8 | Fill colour |
| cmd_valid | output | 1 | Command words valid |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_src_pos | output | 32 | Source start position word |
| cmd_dst_pos | output | 32 | Destination start position word |
| cmd_size | output | 32 | Size word |
| cmd_ctrl | output | 32 | Direction, last-pixel and rotation control |
| cmd_colour | output | 32 | Replicated fill colour |

## Verification
The assertions assume that req_valid is raised only while req_ready is high, and that the request fields are steady during the accepting cycle. The bench driver waits for req_ready at a falling edge before it presents a request, and holds the request for exactly one cycle. The stimulus keeps coordinates small enough that tripling and the far-edge sums never wrap, so the reference arithmetic in the bench stays exact. Downstream readiness follows a fixed stall pattern, so held commands are observed across several cycles.

// File: rtl/blit_pkg.sv
// Package: shared control-word bit positions and the request operation type.
// Assumes 32-bit command words.
package blit_pkg;
    typedef enum logic {OP_COPY = 1'b0, OP_FILL = 1'b1} blit_op_e;

    localparam int CB_LTR    = 0;
    localparam int CB_TTB    = 1;
    localparam int CB_LAST   = 5;
    localparam int CB_ROT_EN = 7;
    localparam int ROT_LSB   = 8;
    localparam int ROT_W     = 3;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ROT = 2'd1, ST_HOLD = 2'd2} blit_state_e;
endpackage

// File: rtl/blit_plan.sv
// Module: combinational planner. It scales horizontal values for 24-bit mode,
// picks the scan direction per axis, and moves the start corners to the far edge
// when an axis scans backwards. It also produces the dividend for the rotation
// remainder. Assumes unsigned coordinates; all sums wrap at COORD_W bits.
module blit_plan
    import blit_pkg::*;
#(
    parameter int COORD_W = 16,
    localparam int RW = COORD_W - 1
) (
    input  blit_op_e           op,
    input  logic               px24,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    output logic [COORD_W-1:0] o_sx,
    output logic [COORD_W-1:0] o_sy,
    output logic [COORD_W-1:0] o_dx,
    output logic [COORD_W-1:0] o_dy,
    output logic [COORD_W-1:0] o_w,
    output logic               ltr,
    output logic               ttb,
    output logic [RW-1:0]      rot_arg
);
    logic [COORD_W-1:0] sx_s, dx_s, w_s;
    logic [COORD_W-1:0] h_m1, w_m1;
    logic [COORD_W:0]   dx_bias;

    // Tripling of horizontal quantities in 24-bit mode.
    always_comb begin
        sx_s = px24 ? COORD_W'(sx + (sx << 1)) : sx;
        dx_s = px24 ? COORD_W'(dx + (dx << 1)) : dx;
        w_s  = px24 ? COORD_W'(w + (w << 1))   : w;
        h_m1 = h - 1'b1;
        w_m1 = w_s - 1'b1;
    end

    // Direction choice and start-corner adjustment.
    always_comb begin
        o_w = w_s;
        if (op == OP_FILL) begin
            ltr  = 1'b1;
            ttb  = 1'b1;
            o_sx = '0;
            o_sy = '0;
            o_dx = dx_s;
            o_dy = dy;
        end else begin
            ttb = !(sy < dy);
            ltr = !(sx_s < dx_s);
            o_sy = ttb ? sy : COORD_W'(sy + h_m1);
            o_dy = ttb ? dy : COORD_W'(dy + h_m1);
            o_sx = ltr ? sx_s : COORD_W'(sx_s + w_m1);
            o_dx = ltr ? dx_s : COORD_W'(dx_s + w_m1);
        end
    end

    // Rotation dividend: forward scans use dx/4, backward scans use (dx+2)/4.
    always_comb begin
        dx_bias = {1'b0, o_dx} + (ltr ? '0 : (COORD_W+1)'(2));
        rot_arg = dx_bias[COORD_W:2];
    end
endmodule

// File: rtl/blit_mod6.sv
// Module: serial remainder-by-6 unit. It shifts in one dividend bit per cycle,
// most significant bit first, so a result takes AW cycles. A start pulse
// reloads the unit. busy is high until the remainder is final.
module blit_mod6 #(
    parameter int AW = 15,
    localparam int CW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] arg,
    output logic          busy,
    output logic [2:0]    rem
);
    logic [AW-1:0] shreg;
    logic [CW-1:0] left;
    logic [3:0]    trial;

    // Next partial remainder, with the next dividend bit appended.
    always_comb begin
        trial = {rem, shreg[AW-1]};
    end

    // Shift-and-subtract step, one dividend bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            left  <= '0;
            rem   <= '0;
        end else if (start) begin
            shreg <= arg;
            left  <= CW'(AW);
            rem   <= '0;
        end else if (left != '0) begin
            shreg <= shreg << 1;
            left  <= left - 1'b1;
            rem   <= (trial >= 4'd6) ? 3'(trial - 4'd6) : trial[2:0];
        end
    end

    assign busy = (left != '0);
endmodule

// File: rtl/blit_pack.sv
// Module: combinational packer. It builds the five command words from the
// registered plan and the rotation remainder. Assumes 2*COORD_W-bit words and
// an 8-bit colour.
module blit_pack
    import blit_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 8,
    localparam int WORD_W = 2 * COORD_W
) (
    input  blit_op_e           op,
    input  logic               px24,
    input  logic [COORD_W-1:0] sx,
    input  logic [COORD_W-1:0] sy,
    input  logic [COORD_W-1:0] dx,
    input  logic [COORD_W-1:0] dy,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    input  logic               ltr,
    input  logic               ttb,
    input  logic [2:0]         rot,
    input  logic [COLOR_W-1:0] colour,
    output logic [WORD_W-1:0]  src_pos,
    output logic [WORD_W-1:0]  dst_pos,
    output logic [WORD_W-1:0]  size,
    output logic [WORD_W-1:0]  ctrl,
    output logic [WORD_W-1:0]  colour_w
);
    // Position and size words: horizontal value in the upper half.
    always_comb begin
        src_pos = {sx, sy};
        dst_pos = {dx, dy};
        size    = {w, h};
    end

    // Control word: direction, last pixel, and rotation in 24-bit mode.
    always_comb begin
        ctrl = '0;
        ctrl[CB_LTR]  = ltr;
        ctrl[CB_TTB]  = ttb;
        ctrl[CB_LAST] = 1'b1;
        if (px24) begin
            ctrl[CB_ROT_EN] = 1'b1;
            ctrl[ROT_LSB +: ROT_W] = rot;
        end
    end

    // Colour word: three copies of the fill colour, zero for copies.
    always_comb begin
        colour_w = '0;
        if (op == OP_FILL) begin
            for (int i = 0; i < 3; i++) begin
                colour_w[i*COLOR_W +: COLOR_W] = colour;
            end
        end
    end
endmodule

// File: rtl/blit_setup_resolver.sv
// Module: top of the rectangle blit setup resolver. It accepts one request at a
// time, discards empty rectangles, registers the planned geometry, waits for the
// rotation remainder in 24-bit mode, and then holds the command words until
// they are taken. Assumes req_valid is raised only while req_ready is high.
module blit_setup_resolver
    import blit_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 8,
    localparam int WORD_W = 2 * COORD_W,
    localparam int RW = COORD_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_fill,
    input  logic               req_px24,
    input  logic [COORD_W-1:0] req_src_x,
    input  logic [COORD_W-1:0] req_src_y,
    input  logic [COORD_W-1:0] req_dst_x,
    input  logic [COORD_W-1:0] req_dst_y,
    input  logic [COORD_W-1:0] req_width,
    input  logic [COORD_W-1:0] req_height,
    input  logic [COLOR_W-1:0] req_colour,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [WORD_W-1:0]  cmd_src_pos,
    output logic [WORD_W-1:0]  cmd_dst_pos,
    output logic [WORD_W-1:0]  cmd_size,
    output logic [WORD_W-1:0]  cmd_ctrl,
    output logic [WORD_W-1:0]  cmd_colour
);
    blit_state_e        state;
    blit_op_e           req_op, r_op;
    logic               accept, empty_rect, rot_start, rot_busy;
    logic [COORD_W-1:0] p_sx, p_sy, p_dx, p_dy, p_w;
    logic               p_ltr, p_ttb;
    logic [RW-1:0]      p_rot_arg;
    logic [COORD_W-1:0] r_sx, r_sy, r_dx, r_dy, r_w, r_h;
    logic               r_ltr, r_ttb, r_px24;
    logic [COLOR_W-1:0] r_colour;
    logic [2:0]         rot_rem;

    // Handshake decode for the request side.
    always_comb begin
        req_op     = req_fill ? OP_FILL : OP_COPY;
        req_ready  = (state == ST_IDLE);
        accept     = req_valid && req_ready;
        empty_rect = (req_width == '0) || (req_height == '0);
        rot_start  = accept && !empty_rect && req_px24;
        cmd_valid  = (state == ST_HOLD);
    end

    blit_plan #(.COORD_W(COORD_W)) u_plan (
        .op(req_op), .px24(req_px24),
        .sx(req_src_x), .sy(req_src_y), .dx(req_dst_x), .dy(req_dst_y),
        .w(req_width), .h(req_height),
        .o_sx(p_sx), .o_sy(p_sy), .o_dx(p_dx), .o_dy(p_dy), .o_w(p_w),
        .ltr(p_ltr), .ttb(p_ttb), .rot_arg(p_rot_arg)
    );

    blit_mod6 #(.AW(RW)) u_mod6 (
        .clk(clk), .rst_n(rst_n), .start(rot_start), .arg(p_rot_arg),
        .busy(rot_busy), .rem(rot_rem)
    );

    // Sequencing: idle, rotation wait, then hold until the command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (accept && !empty_rect) state <= req_px24 ? ST_ROT : ST_HOLD;
                ST_ROT:  if (!rot_busy) state <= ST_HOLD;
                ST_HOLD: if (cmd_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture of the planned geometry at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_op <= OP_COPY;
            {r_sx, r_sy, r_dx, r_dy, r_w, r_h} <= '0;
            {r_ltr, r_ttb, r_px24} <= '0;
            r_colour <= '0;
        end else if (accept && !empty_rect) begin
            r_op     <= req_op;
            r_sx     <= p_sx;
            r_sy     <= p_sy;
            r_dx     <= p_dx;
            r_dy     <= p_dy;
            r_w      <= p_w;
            r_h      <= req_height;
            r_ltr    <= p_ltr;
            r_ttb    <= p_ttb;
            r_px24   <= req_px24;
            r_colour <= req_colour;
        end
    end

    blit_pack #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_pack (
        .op(r_op), .px24(r_px24),
        .sx(r_sx), .sy(r_sy), .dx(r_dx), .dy(r_dy), .w(r_w), .h(r_h),
        .ltr(r_ltr), .ttb(r_ttb), .rot(rot_rem), .colour(r_colour),
        .src_pos(cmd_src_pos), .dst_pos(cmd_dst_pos), .size(cmd_size),
        .ctrl(cmd_ctrl), .colour_w(cmd_colour)
    );
endmodule

// File: rtl/blit_setup_resolver_chk.sv
// Module: assertion checker for the blit setup resolver, attached by bind.
// Assumes the request side is driven only while req_ready is high.
module blit_setup_resolver_chk #(
    parameter int COORD_W = 16,
    localparam int WORD_W = 2 * COORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [COORD_W-1:0] req_width,
    input logic [COORD_W-1:0] req_height,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [WORD_W-1:0] cmd_src_pos,
    input logic [WORD_W-1:0] cmd_dst_pos,
    input logic [WORD_W-1:0] cmd_size,
    input logic [WORD_W-1:0] cmd_ctrl,
    input logic [WORD_W-1:0] cmd_colour
);
    assert_empty_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_width == '0 || req_height == '0))
        |=> (!cmd_valid && req_ready));

    assert_rot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ctrl[10:8] < 3'd6));

    assert_rot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ctrl[7]) |-> (cmd_ctrl[10:8] == 3'd0));

    assert_colour_rep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_colour[7:0] == cmd_colour[15:8] &&
                       cmd_colour[15:8] == cmd_colour[23:16] &&
                       cmd_colour[31:24] == 8'h00));

    assert_last_pel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_ctrl[5]);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid &&
            $stable(cmd_src_pos) && $stable(cmd_dst_pos) && $stable(cmd_size) &&
            $stable(cmd_ctrl) && $stable(cmd_colour)));

    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);
endmodule

bind blit_setup_resolver blit_setup_resolver_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_width(req_width), .req_height(req_height),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src_pos(cmd_src_pos), .cmd_dst_pos(cmd_dst_pos), .cmd_size(cmd_size),
    .cmd_ctrl(cmd_ctrl), .cmd_colour(cmd_colour)
);

// File: tb/blit_setup_resolver_bench.sv
// Bench: scoreboard. The driver computes the expected command words and queues
// them. The monitor compares each taken command at the falling edge.
module blit_setup_resolver_bench;
    typedef struct packed {
        logic [31:0] src, dst, size, ctrl, col;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_fill = 1'b0, req_px24 = 1'b0;
    logic [15:0] req_src_x = '0, req_src_y = '0, req_dst_x = '0, req_dst_y = '0;
    logic [15:0] req_width = '0, req_height = '0;
    logic [7:0]  req_colour = '0;
    logic        req_ready, cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_src_pos, cmd_dst_pos, cmd_size, cmd_ctrl, cmd_colour;

    exp_t      q[$];
    string     tags[$];
    int        checks = 0, fails = 0, cyc = 0;
    bit        done = 1'b0;

    always #4 clk = ~clk;

    blit_setup_resolver u_blit_setup_resolver (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_fill(req_fill), .req_px24(req_px24),
        .req_src_x(req_src_x), .req_src_y(req_src_y),
        .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
        .req_width(req_width), .req_height(req_height), .req_colour(req_colour),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src_pos(cmd_src_pos), .cmd_dst_pos(cmd_dst_pos), .cmd_size(cmd_size),
        .cmd_ctrl(cmd_ctrl), .cmd_colour(cmd_colour)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input bit fill, input bit px24,
        input int sx, input int sy, input int dx, input int dy,
        input int w, input int h, input int c);
        exp_t e;
        bit ltr, ttb;
        int rot;
        if (px24) begin sx = sx * 3; dx = dx * 3; w = w * 3; end
        if (fill) begin
            ltr = 1; ttb = 1; sx = 0; sy = 0;
        end else begin
            ttb = !(sy < dy);
            ltr = !(sx < dx);
            if (!ttb) begin sy = sy + h - 1; dy = dy + h - 1; end
            if (!ltr) begin sx = sx + w - 1; dx = dx + w - 1; end
        end
        rot = ltr ? ((dx / 4) % 6) : (((dx + 2) / 4) % 6);
        e.src  = {sx[15:0], sy[15:0]};
        e.dst  = {dx[15:0], dy[15:0]};
        e.size = {w[15:0], h[15:0]};
        e.ctrl = 32'h20 | {31'd0, ltr} | {30'd0, ttb, 1'b0};
        if (px24) e.ctrl = e.ctrl | 32'h80 | (rot << 8);
        e.col  = fill ? {8'h00, c[7:0], c[7:0], c[7:0]} : 32'h0;
        return e;
    endfunction

    task automatic send(input string tag, input bit fill, input bit px24,
        input int sx, input int sy, input int dx, input int dy,
        input int w, input int h, input int c);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (w != 0 && h != 0) begin
            q.push_back(model(fill, px24, sx, sy, dx, dy, w, h, c));
            tags.push_back(tag);
        end
        req_valid = 1'b1; req_fill = fill; req_px24 = px24;
        req_src_x = 16'(sx); req_src_y = 16'(sy);
        req_dst_x = 16'(dx); req_dst_y = 16'(dy);
        req_width = 16'(w); req_height = 16'(h); req_colour = 8'(c);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0 || cmd_valid) @(negedge clk);
    endtask

    // Monitor: stall pattern, hold check, scoreboard compare.
    initial begin
        exp_t e, held;
        bit   was_stalled = 1'b0;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (was_stalled)
                    check(cmd_valid && {cmd_src_pos, cmd_dst_pos, cmd_size, cmd_ctrl, cmd_colour} == held,
                          "R9", "held command",
                          {cmd_src_pos, cmd_dst_pos, cmd_size, cmd_ctrl, cmd_colour}, held);
                cmd_ready = (cyc % 3) != 1;
                was_stalled = cmd_valid && !cmd_ready;
                held = {cmd_src_pos, cmd_dst_pos, cmd_size, cmd_ctrl, cmd_colour};
                if (cmd_valid) check(!req_ready, "R9", "req_ready while holding", req_ready, 0);
                if (cmd_valid && cmd_ready) begin
                    if (q.size() == 0) begin
                        check(0, "R1", "unexpected command", held, 0);
                    end else begin
                        e = q.pop_front();
                        t = tags.pop_front();
                        check(held == e, t, "command words", held, e);
                    end
                end
            end
        end
    end

    // Watchdog and cycle counter.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                check(0, "R9", "watchdog expired", cyc, 0);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && req_ready, "R10", "reset state", {cmd_valid, req_ready}, 2'b01);

        send("R6", 0, 0, 40, 30, 10, 5, 8, 4, 0);
        send("R3", 0, 0, 10, 2, 10, 9, 5, 6, 0);
        send("R4", 0, 0, 3, 7, 12, 7, 20, 2, 0);
        send("R3", 0, 0, 1, 1, 4, 3, 6, 5, 0);
        send("R4", 0, 0, 9, 9, 9, 9, 3, 3, 0);
        send("R2", 0, 1, 20, 4, 5, 2, 7, 3, 0);
        send("R5", 0, 1, 1, 0, 7, 0, 9, 1, 0);
        send("R5", 0, 1, 2, 5, 3, 1, 4, 2, 0);
        send("R8", 0, 0, 100, 50, 60, 70, 11, 13, 8'h5a);
        send("R7", 1, 0, 77, 88, 15, 25, 30, 40, 8'hc3);
        send("R7", 1, 1, 0, 0, 11, 6, 5, 5, 8'h01);
        for (int x = 0; x < 24; x++)
            send("R5", 1, 1, 0, 0, x, 1, 2, 1, x * 9);
        for (int x = 0; x < 12; x++)
            send("R5", 0, 1, 0, 0, x + 1, 0, 3 + x, 2, 0);

        drain();
        send("R1", 0, 0, 1, 2, 3, 4, 0, 5, 0);
        check(!cmd_valid && req_ready, "R1", "zero width dropped", {cmd_valid, req_ready}, 2'b01);
        send("R1", 1, 1, 1, 2, 3, 4, 6, 0, 8'h77);
        check(!cmd_valid && req_ready, "R1", "zero height dropped", {cmd_valid, req_ready}, 2'b01);
        repeat (20) @(negedge clk);
        check(!cmd_valid, "R1", "no late command", cmd_valid, 0);
        send("R6", 0, 0, 5, 6, 7, 8, 9, 10, 0);
        drain();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R1", "scoreboard empty", q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule